// File: doc/BRIEF.md
# Single-Cycle Register-ALU Datapath

This block is a one-cycle integer datapath. It puts the program counter on an instruction address port and takes a 32-bit instruction word back in the same cycle. It splits that word into fixed fields and reads two operands from a 32-entry by 32-bit register file. It then forms a result with an unsigned add, an unsigned subtract, or an OR with a zero-extended 16-bit immediate.

On the next rising edge, two things happen together: the result lands in the chosen destination register, and the program counter steps by four. The register-file reads are combinational, so a value written on one edge is visible to the very next instruction.

The ALU result and the destination register number are brought out as ports so an environment can follow execution. Instruction words outside the three supported kinds leave the register file untouched.

Top module: `sc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the PC and every register are cleared to zero on that edge, so `imem_addr` reads 0 and every register reads back as 0 afterwards.
- R2: Each rising edge with `rst` low advances `imem_addr` by exactly 4, wrapping modulo 2^32.
- R3: An instruction with op (bits 31:26) = 0, shamt (bits 10:6) = 0 and funct (bits 5:0) = 0x21 gives `alu_result` = reg[rs] + reg[rt] modulo 2^32 and writes it to reg[rd]. Here rs is bits 25:21, rt is bits 20:16 and rd is bits 15:11.
- R4: An instruction with op = 0, shamt = 0 and funct = 0x23 gives `alu_result` = reg[rs] - reg[rt] modulo 2^32 and writes it to reg[rd].
- R5: An instruction with op = 0x0D gives `alu_result` = reg[rs] OR {16'h0000, bits 15:0} and writes it to reg[rt]. The immediate is zero-extended and never sign-extended.
- R6: `dest_reg` equals the rd field when op = 0 and the rt field for every other op.
- R7: Register 0 is never written and always reads as zero, including when it is named as the destination of a supported instruction.
- R8: Any other op, funct or nonzero shamt (with op = 0) is unsupported. It drives `alu_result` to 0 and changes no register, including the one named by `dest_reg`.
- R9: A register written on one edge supplies its new value to an instruction presented in the following cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Current PC, used as the instruction fetch address |
| imem_data | input | 32 | Instruction word returned for `imem_addr` |
| alu_result | output | 32 | Combinational result of the current instruction |
| dest_reg | output | 5 | Register number the current instruction targets |

## Verification
A corrupted register shows up as a wrong `alu_result` in the first cycle that an instruction names that register as a source. The bench chains results through later instructions for this reason, so a lost or stray write is exposed within one or two instructions. A wrong PC appears at `imem_addr` in the cycle right after the faulty edge. A decode error shows up as a wrong `dest_reg` or result in the same cycle the instruction is presented.

// File: rtl/sc_datapath.sv
module sc_datapath #(
  parameter int XLEN    = 32,
  parameter int NREG    = 32,
  parameter int PC_STEP = 4
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] alu_result,
  output logic [4:0]  dest_reg
);
  localparam int RW = $clog2(NREG);
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] rf [NREG];

  wire [5:0]    op    = imem_data[31:26];
  wire [RW-1:0] rs    = imem_data[25:21];
  wire [RW-1:0] rt    = imem_data[20:16];
  wire [RW-1:0] rd    = imem_data[15:11];
  wire [4:0]    shamt = imem_data[10:6];
  wire [5:0]    funct = imem_data[5:0];
  wire [15:0]   imm   = imem_data[15:0];

  wire is_r    = (op == OP_RTYPE) && (shamt == 5'd0);
  wire is_addu = is_r && (funct == FN_ADDU);
  wire is_subu = is_r && (funct == FN_SUBU);
  wire is_ori  = (op == OP_ORI);
  wire reg_we  = is_addu | is_subu | is_ori;

  wire [RW-1:0]   wsel = (op == OP_RTYPE) ? rd : rt;
  wire [XLEN-1:0] op_a = (rs == '0) ? '0 : rf[rs];
  wire [XLEN-1:0] op_b = (rt == '0) ? '0 : rf[rt];
  wire [XLEN-1:0] zimm = {{(XLEN-16){1'b0}}, imm};

  logic [XLEN-1:0] res;
  always_comb begin
    res = '0;
    if (is_addu)     res = op_a + op_b;
    else if (is_subu) res = op_a - op_b;
    else if (is_ori)  res = op_a | zimm;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc + XLEN'(PC_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (reg_we && wsel != '0) begin
      rf[wsel] <= res;
    end
  end

  assign imem_addr  = pc;
  assign alu_result = res;
  assign dest_reg   = wsel;
endmodule

module sc_datapath_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] alu,
  input logic [4:0]  dst,
  input logic [31:0] regs [32],
  input logic [31:0] opa,
  input logic [31:0] opb
);
  logic seen_run;
  always_ff @(posedge clk) seen_run <= rst ? 1'b0 : 1'b1;

  wire r_ok   = instr[31:26] == 6'h00 && instr[10:6] == 5'd0;
  wire addu   = r_ok && instr[5:0] == 6'h21;
  wire subu   = r_ok && instr[5:0] == 6'h23;
  wire ori    = instr[31:26] == 6'h0D;
  wire unsup  = !(addu || subu || ori);

  assert_pc_clear_R1: assert property (@(posedge clk) rst |=> pc == 32'd0);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    seen_run |-> pc == $past(pc) + 32'd4);
  assert_addu_R3: assert property (@(posedge clk) disable iff (rst)
    addu |-> alu == opa + opb);
  assert_ori_dest_R6: assert property (@(posedge clk) disable iff (rst)
    ori |-> dst == instr[20:16]);
  assert_rtype_dest_R6: assert property (@(posedge clk) disable iff (rst)
    instr[31:26] == 6'h00 |-> dst == instr[15:11]);
  assert_zero_reg_R7: assert property (@(posedge clk) disable iff (rst)
    seen_run |-> regs[0] == 32'd0);
  assert_unsup_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (seen_run && unsup) |=> regs[$past(dst)] == $past(regs[dst]));
endmodule

bind sc_datapath sc_datapath_chk u_chk (
  .clk(clk), .rst(rst), .pc(imem_addr), .instr(imem_data),
  .alu(alu_result), .dst(dest_reg), .regs(rf), .opa(op_a), .opb(op_b)
);

// File: tb/tb_sc_datapath.sv
module tb_sc_datapath;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr;
  logic [31:0] imem_data = 32'h0;
  logic [31:0] alu_result;
  logic [4:0]  dest_reg;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sc_datapath dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .alu_result(alu_result), .dest_reg(dest_reg)
  );

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] res;
    logic [4:0]  dst;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h34011234, 32'h00001234, 5'd1},   // R5 ori r1,r0,0x1234
    '{32'h3422F0F0, 32'h0000F2F4, 5'd2},   // R5 R9 ori r2,r1,0xF0F0
    '{32'h00221821, 32'h00010528, 5'd3},   // R3 addu r3,r1,r2
    '{32'h00222023, 32'hFFFF1F40, 5'd4},   // R4 subu r4,r1,r2
    '{32'h3405FFFF, 32'h0000FFFF, 5'd5},   // R5 zero-extend
    '{32'h00853021, 32'h00001F3F, 5'd6},   // R3 wrap
    '{32'h00220021, 32'h00010528, 5'd0},   // R7 write to r0
    '{32'h00003821, 32'h00000000, 5'd7},   // R7 r0 reads zero
    '{32'h8C010000, 32'h00000000, 5'd1},   // R8 bad op
    '{32'h00220820, 32'h00000000, 5'd1},   // R8 bad funct
    '{32'h00204021, 32'h00001234, 5'd8},   // R8 r1 unchanged
    '{32'h00014823, 32'hFFFFEDCC, 5'd9},   // R4 negative wrap
    '{32'h34CA0000, 32'h00001F3F, 5'd10}   // R6 R9 ori dest rt
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  initial begin : watchdog
    #200000;
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check("R1 pc after reset", imem_addr, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (i != 0) @(negedge clk);
      imem_data = VECS[i].ins;
      #1;
      check("R2 pc", imem_addr, 32'(4 * i));
      check("R3/R4/R5/R7/R8 alu", alu_result, VECS[i].res);
      check("R6 dest", {27'h0, dest_reg}, {27'h0, VECS[i].dst});
    end

    // R8 nonzero shamt with addu funct is unsupported and must not write r2
    @(negedge clk) imem_data = 32'h00221061;
    #1 check("R8 shamt!=0 alu", alu_result, 32'h0);
    @(negedge clk) imem_data = 32'h00405821;  // addu r11,r2,r0
    #1 check("R8 r2 unchanged", alu_result, 32'h0000F2F4);

    // R1 mid-run reset clears registers
    do_reset();
    imem_data = 32'h00225821;  // addu r11,r1,r2
    #1;
    check("R1 pc cleared", imem_addr, 32'h0);
    check("R1 regs cleared", alu_result, 32'h0);
    @(negedge clk) #1 check("R2 pc step after reset", imem_addr, 32'h4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule